// File: doc/BRIEF.md
# Flat-Panel Power Sequencer

This block raises and lowers the four power-related enables of a flat display panel in a fixed order, with a timed gap between steps. The enables are the panel logic supply, the pixel data signals, the backlight bias, and the final panel enable. Gaps are measured in pulses of a one-millisecond tick input. The short gap and the long gap are parameters.

The block accepts four requests: full power-up, full power-down, backlight on and backlight off. A full power-up brings the supply up first and the panel enable up last. A full power-down reverses that order. It adds a long settle time between removing the bias and removing the data signals. The backlight requests move only the bias and the panel enable, and leave the supply and the data signals as they are.

While a sequence runs, the block holds `busy_o` high and ignores every new request. The requester must wait for `busy_o` to fall and then request again.

Top module: `panel_pwr_seq`

## Requirements
- R1: An asynchronous reset (rst_ni low) drives all four enables low and busy_o low, and aborts any sequence in progress.
- R2: On an accepted power-up, the supply enable rises on the request edge. The data enable rises on the edge that samples the STEP_MS-th tick after that. The bias enable rises STEP_MS ticks later, and the panel enable rises STEP_MS ticks after the bias.
- R3: On an accepted power-down, the panel enable falls on the request edge. The bias falls STEP_MS ticks later. The data enable falls LONG_MS ticks after the bias, and the supply falls STEP_MS ticks after the data enable.
- R4: A backlight-on request raises the bias on the request edge and the panel enable STEP_MS ticks later. It is ignored unless both the supply and the data enables are high. The supply and data enables are not changed.
- R5: A backlight-off request drops the panel enable on the request edge and the bias STEP_MS ticks later. It is ignored while the supply is low.
- R6: busy_o goes high on the edge that accepts a request and falls on the edge that performs the last step. Requests sampled while busy_o is high have no effect.
- R7: Requests sampled on the same edge are served by priority: power-down, then power-up, then backlight-off, then backlight-on. Only the winner is considered, and the rest are discarded.
- R8: A power-up request is ignored while the supply is high. A power-down request is ignored while the supply is low.
- R9: At every cycle, panel enable implies bias, bias implies data, and data implies supply.
- R10: While a sequence runs, the enables change only on an edge that samples a tick pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_ms_i | input | 1 | One-cycle pulse, once per millisecond |
| pwr_on_i | input | 1 | Full power-up request |
| pwr_off_i | input | 1 | Full power-down request |
| bl_on_i | input | 1 | Backlight-on request |
| bl_off_i | input | 1 | Backlight-off request |
| vdd_en_o | output | 1 | Panel logic supply enable |
| data_en_o | output | 1 | Pixel data signal enable |
| bias_en_o | output | 1 | Backlight bias enable |
| panel_en_o | output | 1 | Final panel enable |
| busy_o | output | 1 | Sequence in progress |

## Verification
The assertions assume that the tick is a pulse one clock wide, so each pulse counts once. They also assume that a request counts only on edges where the machine is idle, so no queueing is modelled. The stimulus keeps to these assumptions: it drives ticks and requests as single-cycle pulses on the falling edge, and never raises a tick in the same cycle as a request. To check that requests are ignored during a sequence, the bench issues them between ticks. It then confirms that the timing of the running sequence is unchanged.

// File: rtl/panel_pwr_seq_pkg.sv
package panel_pwr_seq_pkg;

  typedef struct packed {
    logic vdd;
    logic data;
    logic bias;
    logic panel;
  } rail_t;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ON_DATA,
    ST_ON_BIAS,
    ST_ON_PANEL,
    ST_OFF_BIAS,
    ST_OFF_DATA,
    ST_OFF_VDD,
    ST_BL_PANEL,
    ST_BL_BIAS
  } seq_state_e;

  localparam rail_t RAIL_ALL_OFF = '{vdd: 1'b0, data: 1'b0, bias: 1'b0, panel: 1'b0};

endpackage

// File: rtl/panel_pwr_seq_timer.sv
module panel_pwr_seq_timer #(
  parameter int unsigned STEP_MS = 1,
  parameter int unsigned LONG_MS = 200
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic load_i,
  input  logic long_i,
  output logic expire_o
);

  localparam int unsigned MAX_MS = (LONG_MS > STEP_MS) ? LONG_MS : STEP_MS;
  localparam int unsigned CNT_W  = $clog2(MAX_MS + 1);
  localparam logic [CNT_W-1:0] STEP_C = CNT_W'(STEP_MS);
  localparam logic [CNT_W-1:0] LONG_C = CNT_W'(LONG_MS);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= long_i ? LONG_C : STEP_C;
    end else if (tick_i && (cnt_q != '0)) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  // the gap ends on the edge that samples its last tick
  assign expire_o = tick_i && (cnt_q == CNT_W'(1));

endmodule

// File: rtl/panel_pwr_seq_fsm.sv
module panel_pwr_seq_fsm
  import panel_pwr_seq_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  on_req_i,
  input  logic  off_req_i,
  input  logic  bl_on_req_i,
  input  logic  bl_off_req_i,
  input  logic  expire_i,
  output rail_t rail_o,
  output logic  busy_o,
  output logic  load_o,
  output logic  long_o
);

  seq_state_e state_q, state_d;
  rail_t      rail_q, rail_d;

  always_comb begin
    state_d = state_q;
    rail_d  = rail_q;
    load_o  = 1'b0;
    long_o  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        // strict priority; losers are dropped even when the winner has nothing to do
        if (off_req_i) begin
          if (rail_q.vdd) begin
            rail_d.panel = 1'b0;
            load_o       = 1'b1;
            state_d      = ST_OFF_BIAS;
          end
        end else if (on_req_i) begin
          if (!rail_q.vdd) begin
            rail_d.vdd = 1'b1;
            load_o     = 1'b1;
            state_d    = ST_ON_DATA;
          end
        end else if (bl_off_req_i) begin
          if (rail_q.vdd) begin
            rail_d.panel = 1'b0;
            load_o       = 1'b1;
            state_d      = ST_BL_BIAS;
          end
        end else if (bl_on_req_i) begin
          if (rail_q.vdd && rail_q.data) begin
            rail_d.bias = 1'b1;
            load_o      = 1'b1;
            state_d     = ST_BL_PANEL;
          end
        end
      end
      ST_ON_DATA: if (expire_i) begin
        rail_d.data = 1'b1;
        load_o      = 1'b1;
        state_d     = ST_ON_BIAS;
      end
      ST_ON_BIAS: if (expire_i) begin
        rail_d.bias = 1'b1;
        load_o      = 1'b1;
        state_d     = ST_ON_PANEL;
      end
      ST_ON_PANEL: if (expire_i) begin
        rail_d.panel = 1'b1;
        state_d      = ST_IDLE;
      end
      ST_OFF_BIAS: if (expire_i) begin
        rail_d.bias = 1'b0;
        load_o      = 1'b1;
        long_o      = 1'b1;
        state_d     = ST_OFF_DATA;
      end
      ST_OFF_DATA: if (expire_i) begin
        rail_d.data = 1'b0;
        load_o      = 1'b1;
        state_d     = ST_OFF_VDD;
      end
      ST_OFF_VDD: if (expire_i) begin
        rail_d.vdd = 1'b0;
        state_d    = ST_IDLE;
      end
      ST_BL_PANEL: if (expire_i) begin
        rail_d.panel = 1'b1;
        state_d      = ST_IDLE;
      end
      ST_BL_BIAS: if (expire_i) begin
        rail_d.bias = 1'b0;
        state_d     = ST_IDLE;
      end
      default: begin
        state_d = ST_IDLE;
        rail_d  = RAIL_ALL_OFF;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      rail_q  <= RAIL_ALL_OFF;
    end else begin
      state_q <= state_d;
      rail_q  <= rail_d;
    end
  end

  assign rail_o = rail_q;
  assign busy_o = (state_q != ST_IDLE);

endmodule

// File: rtl/panel_pwr_seq.sv
module panel_pwr_seq
  import panel_pwr_seq_pkg::*;
#(
  parameter int unsigned STEP_MS = 1,
  parameter int unsigned LONG_MS = 200
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_ms_i,
  input  logic pwr_on_i,
  input  logic pwr_off_i,
  input  logic bl_on_i,
  input  logic bl_off_i,
  output logic vdd_en_o,
  output logic data_en_o,
  output logic bias_en_o,
  output logic panel_en_o,
  output logic busy_o
);

  rail_t rail;
  logic  expire, load, long_sel;

  panel_pwr_seq_timer #(
    .STEP_MS(STEP_MS),
    .LONG_MS(LONG_MS)
  ) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick_ms_i),
    .load_i  (load),
    .long_i  (long_sel),
    .expire_o(expire)
  );

  panel_pwr_seq_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .on_req_i    (pwr_on_i),
    .off_req_i   (pwr_off_i),
    .bl_on_req_i (bl_on_i),
    .bl_off_req_i(bl_off_i),
    .expire_i    (expire),
    .rail_o      (rail),
    .busy_o      (busy_o),
    .load_o      (load),
    .long_o      (long_sel)
  );

  assign vdd_en_o   = rail.vdd;
  assign data_en_o  = rail.data;
  assign bias_en_o  = rail.bias;
  assign panel_en_o = rail.panel;

endmodule

// File: rtl/panel_pwr_seq_chk.sv
module panel_pwr_seq_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic tick_ms_i,
  input logic pwr_on_i,
  input logic pwr_off_i,
  input logic bl_on_i,
  input logic bl_off_i,
  input logic vdd_en_o,
  input logic data_en_o,
  input logic bias_en_o,
  input logic panel_en_o,
  input logic busy_o
);

  logic [3:0] rails;
  assign rails = {vdd_en_o, data_en_o, bias_en_o, panel_en_o};

  p_hier_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!panel_en_o || bias_en_o) && (!bias_en_o || data_en_o) && (!data_en_o || vdd_en_o));

  p_tick_paced_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !tick_ms_i) |=> $stable(rails));

  p_supply_first_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(data_en_o) |-> (vdd_en_o && $past(vdd_en_o)));

  p_supply_last_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(vdd_en_o) |-> (rails == 4'b0000));

  p_bl_gate_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && bl_on_i && !pwr_off_i && !pwr_on_i && !bl_off_i && !(vdd_en_o && data_en_o))
    |=> ($stable(rails) && !busy_o));

  p_bl_keeps_supply_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && bl_on_i && !pwr_off_i && !pwr_on_i && !bl_off_i)
    |=> ($stable(vdd_en_o) && $stable(data_en_o)));

  p_off_ignored_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !vdd_en_o && pwr_off_i) |=> (!vdd_en_o && !busy_o));

  p_busy_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !tick_ms_i && (pwr_on_i || pwr_off_i || bl_on_i || bl_off_i))
    |=> $stable(rails));

endmodule

bind panel_pwr_seq panel_pwr_seq_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .tick_ms_i (tick_ms_i),
  .pwr_on_i  (pwr_on_i),
  .pwr_off_i (pwr_off_i),
  .bl_on_i   (bl_on_i),
  .bl_off_i  (bl_off_i),
  .vdd_en_o  (vdd_en_o),
  .data_en_o (data_en_o),
  .bias_en_o (bias_en_o),
  .panel_en_o(panel_en_o),
  .busy_o    (busy_o)
);

// File: tb/panel_pwr_seq_bench.sv
module panel_pwr_seq_bench;

  localparam int unsigned STEP_MS = 2;
  localparam int unsigned LONG_MS = 3;
  localparam int N_VEC = 25;

  // {kind(1:tick 0:request), req{off,on,bl_off,bl_on}, exp{vdd,data,bias,panel,busy}}
  localparam logic [9:0] VEC [N_VEC] = '{
    10'b0_0100_10001, // 0  power-up: supply
    10'b1_0000_10001, // 1
    10'b0_1000_10001, // 2  off while busy: ignored
    10'b1_0000_11001, // 3  data
    10'b1_0000_11001, // 4
    10'b1_0000_11101, // 5  bias
    10'b1_0000_11101, // 6
    10'b1_0000_11110, // 7  panel, idle
    10'b0_0010_11101, // 8  backlight off: panel
    10'b1_0000_11101, // 9
    10'b1_0000_11000, // 10 bias
    10'b0_0001_11101, // 11 backlight on: bias
    10'b1_0000_11101, // 12
    10'b1_0000_11110, // 13 panel
    10'b0_1101_11101, // 14 off+on+bl_on: off wins
    10'b1_0000_11101, // 15
    10'b1_0000_11001, // 16 bias off, long gap
    10'b1_0000_11001, // 17
    10'b1_0000_11001, // 18
    10'b1_0000_10001, // 19 data off
    10'b1_0000_10001, // 20
    10'b1_0000_00000, // 21 supply off
    10'b0_0001_00000, // 22 bl on with supply off
    10'b0_0010_00000, // 23 bl off with supply off
    10'b0_1000_00000  // 24 off with supply off
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0, on_r = 1'b0, off_r = 1'b0, blon_r = 1'b0, bloff_r = 1'b0;
  logic vdd, data, bias, panel, busy;
  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  panel_pwr_seq #(.STEP_MS(STEP_MS), .LONG_MS(LONG_MS)) u_panel_pwr_seq (
    .clk_i(clk), .rst_ni(rst_n), .tick_ms_i(tick),
    .pwr_on_i(on_r), .pwr_off_i(off_r), .bl_on_i(blon_r), .bl_off_i(bloff_r),
    .vdd_en_o(vdd), .data_en_o(data), .bias_en_o(bias), .panel_en_o(panel), .busy_o(busy)
  );

  function automatic string tag_of(input int idx);
    if (idx == 2) return "R6";
    if (idx <= 7) return "R2";
    if (idx <= 10) return "R5";
    if (idx <= 13) return "R4";
    if (idx == 14) return "R7";
    if (idx <= 21) return "R3";
    if (idx == 22) return "R4";
    if (idx == 23) return "R5";
    return "R8";
  endfunction

  task automatic check_out(input string tag, input logic [4:0] exp);
    logic [4:0] act;
    act = {vdd, data, bias, panel, busy};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: outputs %b expected %b", tag, act, exp);
    end
  endtask

  task automatic check_hier();
    checks++;
    if ((panel && !bias) || (bias && !data) || (data && !vdd)) begin
      errors++;
      $display("FAIL R9: rails %b%b%b%b expected ordered nesting", vdd, data, bias, panel);
    end
  endtask

  // drive one-cycle pulse at negedge, sample one ns after the next posedge
  task automatic step(input logic kind, input logic [3:0] req);
    @(negedge clk);
    tick = kind;
    {off_r, on_r, bloff_r, blon_r} = req;
    @(posedge clk);
    #1;
    tick = 1'b0;
    {off_r, on_r, bloff_r, blon_r} = 4'b0000;
  endtask

  initial begin
    while (1) begin
      @(posedge clk);
      cycles++;
      if (cycles >= 100000) begin
        errors++;
        $display("FAIL watchdog: cycles %0d expected below 100000", cycles);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check_out("R1 reset", 5'b00000);
    @(negedge clk);
    rst_n = 1'b1;

    // R10: ticks while idle and off do nothing
    step(1'b1, 4'b0000);
    step(1'b1, 4'b0000);
    check_out("R10 idle ticks", 5'b00000);

    for (int i = 0; i < N_VEC; i++) begin
      step(VEC[i][9], VEC[i][8:5]);
      check_out(tag_of(i), VEC[i][4:0]);
      check_hier();
    end

    // R8: power-up while fully on is ignored
    step(1'b0, 4'b0100);
    for (int i = 0; i < 6; i++) step(1'b1, 4'b0000);
    check_out("R2 repower", 5'b11110);
    step(1'b0, 4'b0100);
    check_out("R8 on while on", 5'b11110);

    // R10: a request during busy plus a long pause without ticks changes nothing
    step(1'b0, 4'b0010);
    repeat (5) step(1'b0, 4'b0000);
    check_out("R10 no tick no step", 5'b11101);
    step(1'b1, 4'b0000);
    check_out("R5 after pause", 5'b11101);
    step(1'b1, 4'b0000);
    check_out("R5 bias drop", 5'b11000);

    // R1: reset in the middle of a power-down aborts it
    step(1'b0, 4'b1000);
    check_out("R3 start", 5'b11001);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check_out("R1 async reset", 5'b00000);
    @(negedge clk);
    rst_n = 1'b1;
    step(1'b1, 4'b0000);
    check_out("R1 stays off", 5'b00000);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule